// File: doc/BRIEF.md
# Serial Register Access Port

This block gives a debug scan chain access to a peripheral's parallel register file. Each scan moves a 40-bit frame through a shift register: 32 bits of data, a 7-bit register address and a one-bit direction flag, entered least significant bit first. When the scan's update strobe arrives, the frame becomes a single-cycle write or read strobe on the peripheral side.

Reads are pipelined by one scan. A read frame only selects a register. The value it returns is latched and is shifted out in the data field of the following scan. Software reading a burst from a register with a side effect, such as a RAM data port that advances its pointer, must therefore end the burst with a frame that addresses a harmless register. The identification register at address 0 serves that purpose.

The TAP controller is outside this block. It supplies a select level plus capture, shift and update enables, each sampled on the block clock.

Top module: `scan_reg_port`

## Requirements
- R1: After reset, `tdo` is 0, no strobe is issued, and the first capture after reset loads a zero frame.
- R2: The frame is bits [31:0] data, [38:32] address, [39] direction. `tdi` enters at bit 39, the register moves one bit toward bit 0 per shift cycle, and `tdo` shows bit 0.
- R3: A frame with direction 1 (write) to an implemented address drives `reg_wr` high for exactly one cycle, the cycle after update. `reg_addr` and `reg_wdata` carry the frame's fields in that cycle.
- R4: A frame with direction 0 (read) to an implemented address drives `reg_rd` high for exactly one cycle, the cycle after update, and `reg_rdata` is sampled in that cycle.
- R5: The next capture loads the sampled read value into bits [31:0] and zeros into bits [39:32].
- R6: Each read frame produces exactly one read strobe. A data-port read followed by an address-0 frame advances the peripheral's pointer once per data-port frame only.
- R7: Addresses at or above `NUM_REGS` produce no strobe. A read of such an address returns 0 on the next scan.
- R8: The scan that follows a write frame captures 0 in its data field.
- R9: While `sel` is low, the capture, shift and update enables have no effect. The shift register, `tdo` and the strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Port is the selected data register |
| capture | input | 1 | Capture enable from the TAP |
| shift | input | 1 | Shift enable from the TAP |
| update | input | 1 | Update enable from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the frame) |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid in the `reg_rd` cycle |

## Verification
The hardest situation to reach is the one-scan lag between a read and its data, combined with a side-effecting register. Every check of a returned value depends on what the previous frame was. To cover it, the bench models a peripheral with a RAM port whose pointer advances on each read, and with the pointer itself exposed as a register. It then runs a burst of two data-port reads closed by an address-0 frame and reads the pointer back to confirm the increment count. Out-of-range and deselected scans are placed right after a read of the identification register. The latched value is then non-zero, so a stray clear or a stray strobe shows up in the next captured frame.

// File: rtl/srp_pkg.sv
package srp_pkg;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 7;
    parameter int FRAME_W = DATA_W + ADDR_W + 1;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Packed MSB first: op at bit FRAME_W-1, data at the bottom.
    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic addr_present(input logic [ADDR_W-1:0] a,
                                          input int unsigned n);
        return 32'(a) < n;
    endfunction

    function automatic frame_t capture_frame(input logic [DATA_W-1:0] d);
        frame_t f;
        f.op   = OP_READ;
        f.addr = '0;
        f.data = d;
        return f;
    endfunction
endpackage

// File: rtl/srp_shifter.sv
module srp_shifter
    import srp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_en,
    input  logic   shf_en,
    input  logic   tdi,
    input  frame_t cap_val,
    output frame_t q,
    output logic   tdo
);
    logic [FRAME_W-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst)
            bits <= '0;
        else if (cap_en)
            bits <= cap_val;
        else if (shf_en)
            bits <= {tdi, bits[FRAME_W-1:1]};
    end

    assign q   = frame_t'(bits);
    assign tdo = bits[0];

    // R2: one position toward bit 0 per shift cycle
    p_shift_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (shf_en && !cap_en) |=> (bits[FRAME_W-2:0] == $past(bits[FRAME_W-1:1])));

    // R9: no enable, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!shf_en && !cap_en) |=> $stable(bits));
endmodule

// File: rtl/srp_issue.sv
module srp_issue
    import srp_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  frame_t            frame,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] rd_hold
);
    logic hit;
    assign hit = addr_present(frame.addr, NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            rd_hold   <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_rd)
                rd_hold <= reg_rdata;
            if (upd_en) begin
                if (!hit || frame.op == OP_WRITE)
                    rd_hold <= '0;
                if (hit) begin
                    reg_addr <= frame.addr;
                    if (frame.op == OP_WRITE) begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= frame.data;
                    end else begin
                        reg_rd <= 1'b1;
                    end
                end
            end
        end
    end

    // R3: write strobe lasts one cycle and follows an update
    p_wr_single_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);
    p_wr_src_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $past(upd_en));
    // R4: read strobe lasts one cycle and follows an update
    p_rd_single_r4: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);
    p_rd_src_r4: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> $past(upd_en));
    // R6: never both strobes at once
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));
    // R7: strobes only for implemented addresses
    p_present_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |-> (32'(reg_addr) < NUM_REGS));
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import srp_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic              tdi,
    output logic              tdo,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic              cap_en, shf_en, upd_en;
    frame_t            sr_q;
    frame_t            cap_val;
    logic [DATA_W-1:0] rd_hold;

    assign cap_en  = sel && capture;
    assign shf_en  = sel && shift;
    assign upd_en  = sel && update;
    assign cap_val = capture_frame(rd_hold);

    srp_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .shf_en  (shf_en),
        .tdi     (tdi),
        .cap_val (cap_val),
        .q       (sr_q),
        .tdo     (tdo)
    );

    srp_issue #(.NUM_REGS(NUM_REGS)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .frame     (sr_q),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rd_hold   (rd_hold)
    );

    // R1: reset leaves no strobe pending
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!reg_wr && !reg_rd));
    // R9: a deselected port issues nothing on the next cycle
    p_sel_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !(reg_wr || reg_rd));
endmodule

// File: tb/sim_scan_reg_port.sv
`timescale 1ns/1ps
module sim_scan_reg_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b1, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic        tdo, reg_wr, reg_rd;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    always #10 clk = ~clk;

    scan_reg_port u0 (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
        .update(update), .tdi(tdi), .tdo(tdo), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Peripheral model: 0 = id, 3 = RAM pointer, 4 = RAM data (pointer advances), others plain
    localparam logic [31:0] ID_VAL = 32'h5A17_0C0D;
    logic [31:0] ram   [8];
    logic [31:0] store [8];
    logic [2:0]  ptr;
    int          wr_count = 0, rd_count = 0;
    logic [6:0]  last_wr_addr;
    logic [31:0] last_wr_data;

    always_comb begin
        case (reg_addr)
            7'd0:    reg_rdata = ID_VAL;
            7'd3:    reg_rdata = {29'd0, ptr};
            7'd4:    reg_rdata = ram[ptr];
            default: reg_rdata = store[reg_addr[2:0]];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            if (reg_rd) begin
                rd_count <= rd_count + 1;
                if (reg_addr == 7'd4) ptr <= ptr + 3'd1;
            end
            if (reg_wr) begin
                wr_count     <= wr_count + 1;
                last_wr_addr <= reg_addr;
                last_wr_data <= reg_wdata;
                if (reg_addr == 7'd3) ptr <= reg_wdata[2:0];
                else store[reg_addr[2:0]] <= reg_wdata;
            end
        end
    end

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct { logic [39:0] val; string tag; } exp_t;
    exp_t        sb_q[$];
    logic [39:0] last_out;
    event        scan_ev;

    initial begin
        forever begin
            @(scan_ev);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(last_out === e.val, e.tag, 64'(last_out), 64'(e.val));
            end
        end
    end

    task automatic scan(input logic s, input logic w, input logic [6:0] a,
                        input logic [31:0] d, input bit chk,
                        input logic [31:0] exp, input string tag);
        logic [39:0] f;
        exp_t e;
        f = {w, a, d};
        if (chk) begin
            e.val = {8'h00, exp};
            e.tag = tag;
            sb_q.push_back(e);
        end
        @(negedge clk); sel = s; capture = 1'b1;
        @(negedge clk); capture = 1'b0; shift = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tdi = f[i];
            last_out[i] = tdo;
            @(negedge clk);
        end
        shift = 1'b0; update = 1'b1;
        @(negedge clk); update = 1'b0;
        @(negedge clk); @(negedge clk);
        sel = 1'b1;
        if (chk) -> scan_ev;
        #1;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int wc, rc;
        for (int i = 0; i < 8; i++) begin
            ram[i]   = 32'hA000_0000 + 32'(i * 17);
            store[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tdo === 1'b0, "R1 tdo", 64'(tdo), 0);
        check(reg_wr === 1'b0 && reg_rd === 1'b0, "R1 strobes", 64'({reg_wr, reg_rd}), 0);
        scan(1, 0, 7'd0, 32'd0, 1, 32'd0, "R1 first capture");
        // R2/R5: id latched and shifted out LSB first
        wc = wr_count;
        scan(1, 1, 7'd5, 32'hCAFE_F00D, 1, ID_VAL, "R2 R5 id readout");
        check(wr_count == wc + 1, "R3 one write strobe", 64'(wr_count), 64'(wc + 1));
        check(last_wr_addr == 7'd5 && last_wr_data == 32'hCAFE_F00D, "R3 write fields",
              64'({last_wr_addr, last_wr_data}), 64'({7'd5, 32'hCAFE_F00D}));
        scan(1, 0, 7'd5, 32'd0, 1, 32'd0, "R8 capture after write");
        scan(1, 0, 7'd0, 32'd0, 1, 32'hCAFE_F00D, "R4 R5 read back");
        // R6 burst on RAM port
        scan(1, 1, 7'd3, 32'd0, 1, ID_VAL, "R6 set pointer");
        rc = rd_count;
        scan(1, 0, 7'd4, 32'd0, 1, 32'd0, "R6 burst start");
        scan(1, 0, 7'd4, 32'd0, 1, ram[0], "R6 ram word 0");
        scan(1, 0, 7'd0, 32'd0, 1, ram[1], "R6 ram word 1");
        check(rd_count == rc + 3, "R6 one strobe per read", 64'(rd_count), 64'(rc + 3));
        scan(1, 0, 7'd3, 32'd0, 1, ID_VAL, "R6 id after burst");
        scan(1, 0, 7'd0, 32'd0, 1, 32'd2, "R6 pointer advanced twice");
        // R7 unimplemented address
        wc = wr_count;
        scan(1, 1, 7'h50, 32'h1234, 1, ID_VAL, "R7 id before unmapped write");
        check(wr_count == wc, "R7 unmapped write ignored", 64'(wr_count), 64'(wc));
        scan(1, 0, 7'd0, 32'd0, 1, 32'd0, "R8 capture after unmapped write");
        rc = rd_count;
        scan(1, 0, 7'h50, 32'd0, 1, ID_VAL, "R7 id before unmapped read");
        check(rd_count == rc, "R7 unmapped read no strobe", 64'(rd_count), 64'(rc));
        scan(1, 0, 7'd0, 32'd0, 1, 32'd0, "R7 unmapped reads zero");
        // R9 deselected scan
        wc = wr_count; rc = rd_count;
        scan(0, 1, 7'd5, 32'hDEAD_BEEF, 0, 32'd0, "");
        check(last_out === 40'd0, "R9 tdo unchanged", 64'(last_out), 0);
        check(wr_count == wc && rd_count == rc, "R9 no strobes",
              64'({wr_count[15:0], rd_count[15:0]}), 64'({wc[15:0], rc[15:0]}));
        scan(1, 0, 7'd5, 32'd0, 1, ID_VAL, "R9 latch kept");
        scan(1, 0, 7'd0, 32'd0, 1, 32'hCAFE_F00D, "R9 register untouched");
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule